// File: doc/BRIEF.md
# Command-Addressed Serial Register Port

This block is a serial slave that lets an external host read and write a 64-location space of 8-bit registers over a three-wire synchronous link framed by an active-high select line. The select, serial clock and serial data inputs all pass through synchronizers into the local system clock. Edges of the serial clock are found on that side, so the serial clock must run much slower than the system clock. At the default setting each half period must last at least six system cycles.

While the select is high, the first byte shifted in is a command. Bit 7 gives the direction (1 means read). Bit 6 asks for a burst. Bits 5 to 0 hold the start address. For a write, the next byte is stored at that address through a one-cycle write strobe on the register-file port. For a read, the addressed byte comes out on the serial data line during the next byte, which the host clocks with a dummy byte.

With the burst flag set, each further data byte goes to the next address, and the address wraps from 63 to 0. With the flag clear, the byte after a single data byte is taken as a fresh command. Lowering the select at any point drops the byte in progress, returns the port to expecting a command, and releases the data output.

Top module: `serial_regport`

## Requirements
- R1: After synchronous reset with select low, the output enable `sdo_oe` is 0 and the write strobe `reg_we` is 0.
- R2: Every byte is 8 bits, most significant bit first. Input bits are taken on rising serial-clock edges. The output bit advances on falling edges. The first bit of a byte is on `sdo` before that byte's first rising edge.
- R3: In a command byte, bit 7 = 1 selects read and bit 7 = 0 selects write. Bit 6 = 1 selects burst. Bits 5..0 are the address.
- R4: After a read command, the byte at the commanded address is shifted out on `sdo` during the following byte. `sdo` carries 0x00 during a command byte.
- R5: After a write command, the next received byte is written to the commanded address by exactly one cycle of `reg_we`, with `reg_addr` and `reg_wdata` valid in that cycle.
- R6: With the burst flag set, each further data byte in the same frame uses the previous address plus one, for reads and for writes.
- R7: With the burst flag clear, the byte received after one data byte is decoded as a new command.
- R8: In burst transfers the address wraps from 63 to 0.
- R9: Lowering the select discards a partial byte without any write, drives `sdo_oe` low, and makes the first byte of the next frame a command. `sdo_oe` is high while the select is high.
- R10: `reg_we` rises at the fourth system-clock rising edge after the serial-clock rising edge that carries the last bit of a write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Frame select from host, active high, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for `sdo` (low = released) |
| reg_addr | output | 6 | Register-file address |
| reg_we | output | 1 | Register-file write strobe, one cycle |
| reg_wdata | output | 8 | Register-file write data |
| reg_rdata | input | 8 | Register-file read data for `reg_addr`, combinational |

## Verification
The main function is tried first with single write-then-read pairs over a table of address and data patterns. The patterns include address 0, address 63, all-zero, all-one and asymmetric bytes such as 0x81 and 0x5A. They show whether the address field is decoded correctly and whether bit order is preserved, because a reversed or shifted byte reads back wrong. Burst writes and reads that start at 62 separate true increments with wrap from a stuck or saturating address. Frames that carry two non-burst commands back to back show whether the port returns to command decoding after one data byte. An aborted half byte, together with a measurement of the write-strobe latency, covers the select abort and the fixed synchronizer delay.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    typedef struct packed {
        logic              rd;
        logic              burst;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] b);
        return cmd_t'(b);
    endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/srp_shift.sv
module srp_shift
    import srp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          sdo,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    logic             sclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    rx_sh_q;
    logic [DW-1:0]    tx_q;
    logic             rise, fall;

    assign rise = sel_s &  sclk_s & ~sclk_q;
    assign fall = sel_s & ~sclk_s &  sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !sel_s) begin
            cnt_q     <= '0;
            rx_sh_q   <= '0;
            tx_q      <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh_q <= {rx_sh_q[DW-2:0], sdi_s};
                if (cnt_q == LAST) begin
                    cnt_q     <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh_q[DW-2:0], sdi_s};
                    tx_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
            if (fall && cnt_q != '0) tx_q <= {tx_q[DW-2:0], 1'b0};
            if (load) tx_q <= load_data;
        end
    end

    assign sdo = tx_q[DW-1];

    // R2: a finished byte leaves the bit counter at the start of the next byte
    a_r2_count_restart: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> (cnt_q == '0));

    // R2: the output bit only moves on a falling edge, a byte end or a load
    a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst || !sel_s)
        (!rise && !fall && !load) |=> $stable(tx_q));
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_s,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    phase_t            phase_q;
    cmd_t              cmd_q;
    cmd_t              rx_cmd;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] waddr_q;
    logic              we_q;
    logic              load_q;

    assign rx_cmd = decode_cmd(rx_byte);

    always_ff @(posedge clk) begin
        if (rst || !sel_s) begin
            phase_q   <= PH_CMD;
            cmd_q     <= '0;
            addr_q    <= '0;
            waddr_q   <= '0;
            we_q      <= 1'b0;
            reg_wdata <= '0;
            load_q    <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            load_q <= 1'b0;
            if (byte_done) begin
                if (phase_q == PH_CMD) begin
                    cmd_q   <= rx_cmd;
                    addr_q  <= rx_cmd.addr;
                    phase_q <= PH_DATA;
                    load_q  <= rx_cmd.rd;
                end else begin
                    if (!cmd_q.rd) begin
                        we_q      <= 1'b1;
                        reg_wdata <= rx_byte;
                        waddr_q   <= addr_q;
                    end
                    if (cmd_q.burst) begin
                        addr_q <= addr_q + ADDR_W'(1);
                        load_q <= cmd_q.rd;
                    end else begin
                        phase_q <= PH_CMD;
                    end
                end
            end
        end
    end

    assign reg_we    = we_q;
    assign reg_addr  = we_q ? waddr_q : addr_q;
    assign load      = load_q;
    assign load_data = reg_rdata;

    // R5: one strobe per data byte
    a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6, R8: burst steps the address by one, modulo 64
    a_r6_burst_step: assert property (@(posedge clk) disable iff (rst)
        (sel_s && byte_done && phase_q == PH_DATA && cmd_q.burst)
        |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R7: without burst one data byte returns to command decoding
    a_r7_back_to_cmd: assert property (@(posedge clk) disable iff (rst)
        (sel_s && byte_done && phase_q == PH_DATA && !cmd_q.burst)
        |=> (phase_q == PH_CMD));

    // R4: output is loaded only under a read command
    a_r4_load_on_read: assert property (@(posedge clk) disable iff (rst)
        load |-> cmd_q.rd);

    // R9: a dropped select leaves no write and a command phase
    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        !sel_s |=> (phase_q == PH_CMD && !reg_we));
endmodule

// File: rtl/serial_regport.sv
module serial_regport
    import srp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              sel_s, sclk_s, sdi_s;
    logic              load, byte_done, sdo_raw;
    logic [DATA_W-1:0] load_data, rx_byte;

    srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({sel, sclk, sdi}), .q(pins_s)
    );
    assign {sel_s, sclk_s, sdi_s} = pins_s;

    srp_shift #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sel_s(sel_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .load(load), .load_data(load_data), .sdo(sdo_raw),
        .byte_done(byte_done), .rx_byte(rx_byte)
    );

    srp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sel_s(sel_s), .byte_done(byte_done),
        .rx_byte(rx_byte), .load(load), .load_data(load_data),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    assign sdo_oe = sel_s;
    assign sdo    = sel_s & sdo_raw;

    // R9: output is released only after the select has dropped
    a_r9_oe_follows_sel: assert property (@(posedge clk) disable iff (rst)
        (!sel && $past(!sel) && $past(!sel, 2)) |-> !sdo_oe);
endmodule

// File: tb/tb_serial_regport.sv
`timescale 1ns/1ps
module tb_serial_regport;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic       sdo, sdo_oe, reg_we;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [64];
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    serial_regport dut (
        .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 3 + 8'h11);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] r);
        for (int b = 7; b >= 0; b--) begin
            sdi = o[b];
            #HALF;
            r[b] = sdo;
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
        end
    endtask

    task automatic frame_begin();
        sel = 1'b1;
        #HALF;
    endtask

    task automatic frame_end();
        #HALF;
        sel = 1'b0;
        #(2*HALF);
    endtask

    task automatic wr1(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] r;
        frame_begin();
        xfer({2'b00, a}, r);
        xfer(d, r);
        frame_end();
    endtask

    task automatic rd1(input logic [5:0] a, output logic [7:0] cmd_r, output logic [7:0] d);
        frame_begin();
        xfer({2'b10, a}, cmd_r);
        xfer(8'h00, d);
        frame_end();
    endtask

    // address, data
    localparam logic [13:0] VEC [6] = '{
        {6'd0,  8'h5A},
        {6'd63, 8'hC3},
        {6'd21, 8'h00},
        {6'd42, 8'hFF},
        {6'd1,  8'h81},
        {6'd30, 8'h7E}
    };

    initial begin
        logic [7:0] r, c;
        int first, highs;
        @(posedge clk); #1;
        repeat (4) @(posedge clk);
        #1;
        check("R1 sdo_oe after reset", {7'd0, sdo_oe}, 8'd0);
        check("R1 reg_we after reset", {7'd0, reg_we}, 8'd0);
        rst = 1'b0;
        @(posedge clk); #1;

        sel = 1'b1;
        #HALF;
        check("R9 sdo_oe with select high", {7'd0, sdo_oe}, 8'd1);
        sel = 1'b0;
        #HALF;

        // table: single write then single read
        for (int i = 0; i < 6; i++) begin
            wr1(VEC[i][13:8], VEC[i][7:0]);
            check("R5 written location", mem[VEC[i][13:8]], VEC[i][7:0]);
            rd1(VEC[i][13:8], c, r);
            check("R4 sdo during command byte", c, 8'h00);
            check("R2 R3 R4 read back MSB first", r, VEC[i][7:0]);
        end

        // burst write from 62 with wrap
        frame_begin();
        xfer(8'h7E, r);
        xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); xfer(8'h44, r);
        frame_end();
        check("R6 burst write 62", mem[62], 8'h11);
        check("R6 burst write 63", mem[63], 8'h22);
        check("R8 burst write wrap 0", mem[0], 8'h33);
        check("R8 burst write wrap 1", mem[1], 8'h44);

        // burst read from 62 with wrap
        frame_begin();
        xfer(8'hFE, r);
        xfer(8'h00, r); check("R6 burst read 62", r, 8'h11);
        xfer(8'h00, r); check("R6 burst read 63", r, 8'h22);
        xfer(8'h00, r); check("R8 burst read wrap 0", r, 8'h33);
        xfer(8'h00, r); check("R8 burst read wrap 1", r, 8'h44);
        frame_end();

        // two non-burst writes in one frame
        frame_begin();
        xfer(8'h0A, r); xfer(8'h66, r);
        xfer(8'h0B, r); xfer(8'h77, r);
        frame_end();
        check("R7 first write in frame", mem[10], 8'h66);
        check("R7 second command decoded", mem[11], 8'h77);

        // two non-burst reads in one frame
        frame_begin();
        xfer(8'h8A, c); xfer(8'h00, r);
        check("R7 first read in frame", r, 8'h66);
        xfer(8'h8B, c);
        check("R7 sdo zero in second command", c, 8'h00);
        xfer(8'h00, r);
        check("R7 second read in frame", r, 8'h77);
        frame_end();

        // abort partway through a data byte
        frame_begin();
        xfer(8'h05, r);
        for (int b = 0; b < 4; b++) begin
            sdi = 1'b1; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
        end
        sel = 1'b0;
        #HALF;
        check("R9 sdo_oe released", {7'd0, sdo_oe}, 8'd0);
        #(4*HALF);
        check("R9 no write on abort", mem[5], 8'h20);
        rd1(6'd5, c, r);
        check("R9 next frame starts with command", r, 8'h20);

        // write strobe latency
        frame_begin();
        xfer(8'h09, r);
        for (int b = 7; b >= 1; b--) begin
            sdi = b[0]; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
        end
        sdi = 1'b0;
        #HALF;
        sclk = 1'b1;
        first = 0; highs = 0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1;
            if (reg_we) begin
                highs++;
                if (first == 0) first = k;
            end
        end
        #10;
        sclk = 1'b0;
        frame_end();
        check("R10 strobe edge count", 8'(first), 8'd4);
        check("R5 strobe width", 8'(highs), 8'd1);
        check("R5 latency write data", mem[9], 8'hAA);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule